// File: doc/BRIEF.md
# Vertical-Interval Coast Window Generator

This block produces the internal hold signals that tell a pixel-clock PLL, and separately the input clamp, to stop following horizontal sync around the vertical sync interval. It runs on the pixel clock. It counts leading edges of the horizontal sync input to number the lines of each field, and it keeps the length of the field that has just ended. From that length it predicts where the next vertical sync will fall. The hold can therefore be raised a programmed number of lines early, and it is released a programmed number of lines after the vertical sync line.

Because the early start comes from the length of the previous field and not from the current sync, the start line can differ by one between the two fields of an interlaced frame. An external hold pin with selectable active level can replace the internal window. Two window outputs share the line state and the source selection. One drives the PLL hold and the other the clamp hold, and each has its own pair of before and after line counts.

Top module: `coast_window_gen`

## Requirements
- R1: After reset, with the internal source selected and no vertical sync seen yet, both hold outputs are low.
- R2: Every state or output change that a horizontal sync leading edge (rising edge of `hsyncIn`) causes appears exactly 8 clock edges after the edge at which `hsyncIn` is first sampled high.
- R3: The line number advances by one on every horizontal sync leading edge, including lines where a hold is asserted and lines where the external pin is selected. It saturates at its maximum value.
- R4: A rising edge of `vsyncIn` makes the next horizontal sync leading edge, or one in the same clock, line 1 of a new field.
- R5: With the internal source selected and at least one field started, a hold output is high on line 1 and on the following `post` lines, that is lines 1 to post+1.
- R6: At each field start the retained value becomes the last line number of the ended field plus one. A hold output is then also high from line (retained − pre) onward. A pre count of 0 adds no early lines.
- R7: With pre = 6, a field of 264 lines moves the early start of the next field to line 259, and a field of 263 lines moves it to line 258.
- R8: With `useInternal` = 0, both outputs follow `coastPin` directly when `pinActiveHigh` = 1 and its inverse when `pinActiveHigh` = 0, with no clock delay.
- R9: The clamp hold uses its own pre and post counts with the same line state. With pre = 2 it starts at line retained − 2.
- R10: No early start is produced until one complete field, bounded by two vertical sync edges, has been counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsyncIn | input | 1 | Horizontal sync, active high, synchronous to clk |
| vsyncIn | input | 1 | Vertical sync, active high, synchronous to clk |
| coastPin | input | 1 | External hold request |
| useInternal | input | 1 | 1 selects the internal window, 0 selects the pin |
| pinActiveHigh | input | 1 | Active level of coastPin (1 high, 0 low) |
| pllPreLines | input | 8 | Early lines for the PLL hold |
| pllPostLines | input | 8 | Trailing lines for the PLL hold |
| clpPreLines | input | 8 | Early lines for the clamp hold |
| clpPostLines | input | 8 | Trailing lines for the clamp hold |
| pllCoast | output | 1 | PLL hold output |
| clampCoast | output | 1 | Clamp hold output |

## Verification
A wrong line number or retained length shows at the outputs as an early start one or more lines off, and only in the field after the fault. The bench therefore runs several whole fields of unequal length and records the line on which each early start rises. A wrong alignment delay moves every output edge by whole clocks, and a comparison on every cycle exposes that on the first vertical sync line. A lost count during pin mode becomes visible only after the block returns to the internal source, which is why the bench runs a stretch of internal operation after the pin phase.

// File: rtl/coast_win_pkg.sv
package coast_win_pkg;

  // strobes from the sync control to the line datapath
  typedef struct packed {
    logic lineTick;    // aligned line event
    logic fieldStart;  // this line event opens a new field
  } lineStrobe_t;

endpackage

// File: rtl/coast_sync_ctrl.sv
module coast_sync_ctrl
  import coast_win_pkg::*;
#(
  parameter int ALIGN_DLY = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hsyncIn,
  input  logic        vsyncIn,
  output lineStrobe_t strobe
);

  localparam int DLY_W = (ALIGN_DLY > 2) ? $clog2(ALIGN_DLY) : 1;

  logic             hsPrev;
  logic             vsPrev;
  logic             vsPending;
  logic             armed;
  logic             fsArmed;
  logic [DLY_W-1:0] dlyCnt;
  logic             hsEdge;
  logic             vsEdge;

  assign hsEdge = hsyncIn & ~hsPrev;
  assign vsEdge = vsyncIn & ~vsPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsPrev    <= 1'b0;
      vsPrev    <= 1'b0;
      vsPending <= 1'b0;
      armed     <= 1'b0;
      fsArmed   <= 1'b0;
      dlyCnt    <= '0;
    end else begin
      hsPrev <= hsyncIn;
      vsPrev <= vsyncIn;
      if (hsEdge) begin
        // a vertical edge binds to this line or the next one
        armed     <= 1'b1;
        dlyCnt    <= DLY_W'(ALIGN_DLY - 1);
        fsArmed   <= vsPending | vsEdge;
        vsPending <= 1'b0;
      end else begin
        vsPending <= vsPending | vsEdge;
        if (armed) begin
          if (dlyCnt == '0) armed  <= 1'b0;
          else              dlyCnt <= dlyCnt - 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.lineTick   = armed && (dlyCnt == '0);
    strobe.fieldStart = armed && (dlyCnt == '0) && fsArmed;
  end

  // R2: an aligned event is a single clock wide
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.lineTick |=> !strobe.lineTick);

  // R4: a vertical edge without a line edge is remembered
  p_vs_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vsEdge && !hsEdge) |=> vsPending);

endmodule

// File: rtl/coast_line_dp.sv
module coast_line_dp
  import coast_win_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lineStrobe_t       strobe,
  output logic [LINE_W-1:0] lineNum,
  output logic [LINE_W:0]   retained,
  output logic              fieldSeen,
  output logic              prevValid
);

  localparam int RET_W = LINE_W + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineNum   <= '0;
      retained  <= '0;
      fieldSeen <= 1'b0;
      prevValid <= 1'b0;
    end else if (strobe.lineTick) begin
      if (strobe.fieldStart) begin
        retained  <= RET_W'(lineNum) + RET_W'(1);
        lineNum   <= LINE_W'(1);
        prevValid <= fieldSeen;
        fieldSeen <= 1'b1;
      end else if (lineNum != '1) begin
        lineNum <= lineNum + LINE_W'(1);
      end
    end
  end

  // R3: one step per ordinary line event
  p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.lineTick && !strobe.fieldStart && (lineNum != '1))
      |=> (lineNum == $past(lineNum) + LINE_W'(1)));

  // R3: no movement between line events
  p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.lineTick |=> $stable(lineNum));

  // R4: a field start restarts numbering at one
  p_field_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fieldStart |=> ((lineNum == LINE_W'(1)) && fieldSeen));

  // R6: retained length is the ended field's last line plus one
  p_retain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fieldStart |=> (retained == RET_W'($past(lineNum)) + RET_W'(1)));

  // R10: a valid prediction needs an earlier field start
  p_valid_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prevValid |-> fieldSeen);

endmodule

// File: rtl/coast_window.sv
module coast_window #(
  parameter int LINE_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic [LINE_W-1:0] lineNum,
  input  logic [LINE_W:0]   retained,
  input  logic              fieldSeen,
  input  logic              prevValid,
  input  logic [CNT_W-1:0]  preLines,
  input  logic [CNT_W-1:0]  postLines,
  input  logic              useInternal,
  input  logic              coastPin,
  input  logic              pinActiveHigh,
  output logic              coastOut
);

  localparam int WIDE_W = ((LINE_W + 1) > CNT_W) ? (LINE_W + 1) : CNT_W;
  localparam int SUM_W  = WIDE_W + 1;

  logic [SUM_W-1:0] lineWide;
  logic [SUM_W-1:0] postEnd;
  logic [SUM_W-1:0] preReach;
  logic             inPost;
  logic             inPre;

  always_comb begin
    lineWide = SUM_W'(lineNum);
    postEnd  = SUM_W'(postLines) + SUM_W'(1);
    preReach = lineWide + SUM_W'(preLines);
    inPost   = fieldSeen && (lineWide <= postEnd);
    inPre    = prevValid && (preLines != '0) && (preReach >= SUM_W'(retained));
    coastOut = useInternal ? (inPost || inPre) : (coastPin ~^ pinActiveHigh);
  end

endmodule

// File: rtl/coast_window_gen.sv
module coast_window_gen
  import coast_win_pkg::*;
#(
  parameter int LINE_W    = 12,
  parameter int CNT_W     = 8,
  parameter int ALIGN_DLY = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsyncIn,
  input  logic             vsyncIn,
  input  logic             coastPin,
  input  logic             useInternal,
  input  logic             pinActiveHigh,
  input  logic [CNT_W-1:0] pllPreLines,
  input  logic [CNT_W-1:0] pllPostLines,
  input  logic [CNT_W-1:0] clpPreLines,
  input  logic [CNT_W-1:0] clpPostLines,
  output logic             pllCoast,
  output logic             clampCoast
);

  lineStrobe_t       strobe;
  logic [LINE_W-1:0] lineNum;
  logic [LINE_W:0]   retained;
  logic              fieldSeen;
  logic              prevValid;

  coast_sync_ctrl #(.ALIGN_DLY(ALIGN_DLY)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .hsyncIn (hsyncIn),
    .vsyncIn (vsyncIn),
    .strobe  (strobe)
  );

  coast_line_dp #(.LINE_W(LINE_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .lineNum   (lineNum),
    .retained  (retained),
    .fieldSeen (fieldSeen),
    .prevValid (prevValid)
  );

  coast_window #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_pllWin (
    .lineNum       (lineNum),
    .retained      (retained),
    .fieldSeen     (fieldSeen),
    .prevValid     (prevValid),
    .preLines      (pllPreLines),
    .postLines     (pllPostLines),
    .useInternal   (useInternal),
    .coastPin      (coastPin),
    .pinActiveHigh (pinActiveHigh),
    .coastOut      (pllCoast)
  );

  coast_window #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_clpWin (
    .lineNum       (lineNum),
    .retained      (retained),
    .fieldSeen     (fieldSeen),
    .prevValid     (prevValid),
    .preLines      (clpPreLines),
    .postLines     (clpPostLines),
    .useInternal   (useInternal),
    .coastPin      (coastPin),
    .pinActiveHigh (pinActiveHigh),
    .coastOut      (clampCoast)
  );

endmodule

// File: tb/coast_window_gen_tb.sv
`timescale 1ns/1ps
module coast_window_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs = 1'b0;
  logic       vs = 1'b0;
  logic       pin = 1'b0;
  logic       useInt = 1'b1;
  logic       polHigh = 1'b1;
  logic [7:0] pllPre = '0;
  logic [7:0] pllPost = '0;
  logic [7:0] clpPre = '0;
  logic [7:0] clpPost = '0;
  logic       pllCoast;
  logic       clampCoast;

  always #4 clk = ~clk;

  coast_window_gen u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .hsyncIn       (hs),
    .vsyncIn       (vs),
    .coastPin      (pin),
    .useInternal   (useInt),
    .pinActiveHigh (polHigh),
    .pllPreLines   (pllPre),
    .pllPostLines  (pllPost),
    .clpPreLines   (clpPre),
    .clpPostLines  (clpPost),
    .pllCoast      (pllCoast),
    .clampCoast    (clampCoast)
  );

  int    nChecks = 0;
  int    nFails = 0;
  string curReq = "R1";
  bit    cmpOn = 0;
  bit    recOn = 0;

  // behavioural reference state
  int mLine = 0;
  int mRet = 0;
  bit mSeen = 0;
  bit mValid = 0;
  bit mHsPrev = 0;
  bit mVsPrev = 0;
  bit mVsPend = 0;
  int cyc = 0;
  int dueQ[$];
  bit fsQ[$];
  int pllRise[$];
  int clpRise[$];
  logic pllPrevS = 1'b0;
  logic clpPrevS = 1'b0;

  task automatic check(logic act, logic exp, string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic checkInt(int act, int exp, string req);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit expWin(int pre, int post);
    if (!mSeen) return 1'b0;
    if (mLine <= post + 1) return 1'b1;
    return mValid && (pre != 0) && (mLine + pre >= mRet);
  endfunction

  // reference model: events take effect 8 clocks after the sampled edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mLine = 0; mRet = 0; mSeen = 0; mValid = 0;
      mHsPrev = 0; mVsPrev = 0; mVsPend = 0;
      dueQ.delete(); fsQ.delete();
    end else begin
      while (dueQ.size() > 0 && dueQ[0] == cyc) begin
        bit fs;
        void'(dueQ.pop_front());
        fs = fsQ.pop_front();
        if (fs) begin
          mRet = mLine + 1; mLine = 1; mValid = mSeen; mSeen = 1;
        end else if (mLine < 4095) begin
          mLine = mLine + 1;
        end
      end
      if (hs && !mHsPrev) begin
        dueQ.push_back(cyc + 8);
        fsQ.push_back(mVsPend || (vs && !mVsPrev));
        mVsPend = 0;
      end else if (vs && !mVsPrev) begin
        mVsPend = 1;
      end
      mHsPrev = hs;
      mVsPrev = vs;
    end
    cyc++;
  end

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (cmpOn) begin
      logic expP, expC;
      expP = useInt ? expWin(int'(pllPre), int'(pllPost)) : (pin == polHigh);
      expC = useInt ? expWin(int'(clpPre), int'(clpPost)) : (pin == polHigh);
      check(pllCoast, expP, curReq);
      check(clampCoast, expC, curReq);
      if (recOn) begin
        if (pllCoast && !pllPrevS && mLine > int'(pllPost) + 1) pllRise.push_back(mLine);
        if (clampCoast && !clpPrevS && mLine > int'(clpPost) + 1) clpRise.push_back(mLine);
      end
      pllPrevS = pllCoast;
      clpPrevS = clampCoast;
    end
  end

  task automatic runLine(bit vsFlag);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      hs = (i < 4);
      vs = vsFlag && (i >= 10) && (i < 18);
    end
  endtask

  task automatic runField(int len);
    for (int i = 1; i <= len; i++) runLine(i == len);
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pllCoast, 1'b0, "R1");
    check(clampCoast, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    cmpOn = 1;
    pllPre = 8'd6; pllPost = 8'd3; clpPre = 8'd2; clpPost = 8'd0;

    // R1: lines without any vertical sync give no hold
    curReq = "R1";
    repeat (30) runLine(0);

    // R10: partial field then first full field, no early start
    curReq = "R10";
    runField(10);
    runField(264);

    // R6: predicted early start in following fields
    curReq = "R6";
    recOn = 1;
    runField(263);
    runField(264);
    recOn = 0;
    curReq = "R5";
    repeat (5) runLine(0);

    // R7: start line follows the length of the field before
    checkInt(pllRise.size(), 2, "R7");
    if (pllRise.size() == 2) begin
      checkInt(pllRise[0], 259, "R7");
      checkInt(pllRise[1], 258, "R7");
    end
    // R9: clamp hold with its own counts
    checkInt(clpRise.size(), 2, "R9");
    if (clpRise.size() == 2) begin
      checkInt(clpRise[0], 263, "R9");
      checkInt(clpRise[1], 262, "R9");
    end

    // R4 / R5: zero counts leave only the vertical sync line
    pllPre = '0; pllPost = '0; clpPre = '0; clpPost = '0;
    curReq = "R4";
    runField(12);
    runField(12);
    runField(12);
    // R2: exact alignment of the line-1 hold edge
    @(negedge clk);
    hs = 1'b1; vs = 1'b0;
    @(posedge clk);
    repeat (7) @(posedge clk);
    #2 check(pllCoast, 1'b0, "R2");
    @(posedge clk);
    #2 check(pllCoast, 1'b1, "R2");
    @(negedge clk);
    hs = 1'b0;
    repeat (10) @(negedge clk);
    curReq = "R5";
    repeat (11) runLine(0);

    // R8: external pin path, both levels
    curReq = "R8";
    @(negedge clk);
    useInt = 1'b0; polHigh = 1'b1; pin = 1'b1;
    #1;
    check(pllCoast, 1'b1, "R8");
    check(clampCoast, 1'b1, "R8");
    @(negedge clk);
    polHigh = 1'b0;
    #1;
    check(pllCoast, 1'b0, "R8");
    check(clampCoast, 1'b0, "R8");
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      pin = k[0];
      polHigh = k[1];
      runLine(k == 3);
    end

    // R3: counting went on while the pin was selected
    curReq = "R3";
    @(negedge clk);
    useInt = 1'b1;
    pllPre = 8'd3; pllPost = 8'd1; clpPre = 8'd1; clpPost = 8'd2;
    repeat (6) runLine(0);
    runField(20);
    runField(20);
    repeat (5) runLine(0);

    cmpOn = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule